// File: doc/BRIEF.md
# Pulse-Position Reader Command Decoder

This block receives the reader-to-card direction of a contactless link in which each pair of data bits is sent as one carrier drop placed in one of four time slots. Samples arrive in groups of four, one group per half slot. Each group is inverted on entry, so a carrier drop reads as 1. After a quiet stretch the decoder locks onto the first drop, takes the sample lane in which that drop appeared first, and follows one start symbol and then data symbols. It packs two bits per symbol into bytes and writes them into a small frame buffer.

An odd-parity bit is worked out for every stored byte and kept in a parity word for later display. A drop in the first half of the first slot closes the frame. The decoder then gives a one-cycle done pulse together with the byte count, the parity word, the sync lane offset and an overflow flag. These outputs keep their values until the next frame locks. The stored bytes are read through an asynchronous read port.

Top module: `ppm_cmd_decoder`

## Requirements
- R1: After reset, frame_done, frame_len, frame_parity, sync_ofs and frame_ovf are all zero.
- R2: A sample value of 0 on grp_raw means a carrier drop and 1 means carrier present. A group of all ones is quiet.
- R3: While idle, a group containing a drop locks the decoder only if the 8 groups before it were all quiet. Any other drop group restarts the quiet count.
- R4: At lock, sync_ofs takes the index of the highest-numbered drop bit in the locking group (bit 3 is the earliest sample). From then on, only that bit of each group is decoded.
- R5: After lock, one start symbol of 8 groups follows. A drop in the second half of slot 3 or slot 4 starts data reception. A drop in slot 1 or 2 drops the frame without a done pulse.
- R6: A data symbol whose drop falls in the second half of slot s gives the pair s mod 4 (slot 1 gives 01, slot 2 gives 10, slot 3 gives 11, slot 4 gives 00). Each pair enters bits 7:6 of a right-shifting register, so the first pair of a byte ends up in bits 1:0. A byte is stored after four symbols.
- R7: A second drop within one symbol, or a symbol with no drop, abandons the frame without a done pulse.
- R8: During data reception, a drop in the first half of slot 1 ends the frame and discards any partial byte. If no byte was stored, the single byte 0xF0 becomes the frame and frame_len is 1.
- R9: During data reception, a drop in the first half of slots 2 to 4 abandons the frame. During the start symbol, first-half drops are ignored.
- R10: For each stored byte, its odd-parity bit (1 when the byte has an even number of ones) is shifted into bit 0 of the 32-bit frame_parity word.
- R11: If a byte completes while MAX_BYTES bytes are already stored, the frame ends at once with frame_ovf set and frame_len equal to MAX_BYTES. The extra byte is discarded.
- R12: frame_done is high for exactly one cycle, in the cycle after the clock edge that takes the closing group. frame_len, frame_parity, sync_ofs and frame_ovf hold their values until the next lock.
- R13: Cycles with grp_vld low change nothing, whatever grp_raw carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_vld | input | 1 | A sample group is present this cycle |
| grp_raw | input | GRP_W (4) | Raw samples of one half slot, bit 3 earliest, 0 = drop |
| rd_addr | input | clog2(MAX_BYTES) (5) | Frame buffer read address |
| rd_data | output | 8 | Frame buffer byte at rd_addr |
| frame_done | output | 1 | One-cycle pulse at frame end |
| frame_len | output | clog2(MAX_BYTES+1) (6) | Bytes stored in the current frame |
| frame_parity | output | PAR_W (32) | Odd-parity bits of the stored bytes, newest in bit 0 |
| sync_ofs | output | clog2(GRP_W) (2) | Sample lane chosen at lock |
| frame_ovf | output | 1 | The frame was cut at MAX_BYTES |

## Verification
On every cycle the assertions check the following. The done pulse never lasts two cycles. The length never passes the cap, and equals the cap when an overflowed frame completes. A finished frame never reports zero bytes. A done pulse only follows an accepted group, and the lane offset does not move at the pulse. Only the bench scenarios can show the rest: that lock needs eight quiet groups, that the earliest lane is chosen and other lanes are ignored, how slot positions map to bit pairs, the 0xF0 marker, and the discarding of frames with a bad start symbol, a double drop, an empty symbol or a misplaced first-half drop.

// File: rtl/ppm_dec_pkg.sv
package ppm_dec_pkg;
  typedef enum logic [1:0] {
    DS_IDLE = 2'd0,
    DS_SOF  = 2'd1,
    DS_RECV = 2'd2
  } dec_state_e;

  localparam logic [7:0] EMPTY_MARK = 8'hF0;

  function automatic logic odd_par_bit(input logic [7:0] b);
    return ~^b;
  endfunction
endpackage

// File: rtl/ppm_sync_finder.sv
module ppm_sync_finder #(
  parameter int QUIET = 8,
  parameter int GW    = 4,
  localparam int OW   = $clog2(GW),
  localparam int CW   = $clog2(QUIET + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          vld,
  input  logic [GW-1:0] drops,
  output logic          hit,
  output logic [OW-1:0] ofs
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!en) begin
      cnt_d = '0;
    end else if (vld) begin
      if (drops == '0) begin
        if (cnt_q != CW'(QUIET)) cnt_d = cnt_q + CW'(1);
      end else begin
        cnt_d = '0;
      end
    end
  end

  assign hit = en & vld & (|drops) & (cnt_q == CW'(QUIET));

  // highest index is the earliest sample in time
  always_comb begin
    ofs = '0;
    for (int i = 0; i < GW; i++) begin
      if (drops[i]) ofs = OW'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ppm_byte_packer.sv
module ppm_byte_packer
  import ppm_dec_pkg::*;
#(
  parameter int MAX_BYTES = 32,
  parameter int PAR_W     = 32,
  localparam int AW       = $clog2(MAX_BYTES),
  localparam int LW       = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             pair_vld,
  input  logic [1:0]       pair,
  input  logic             mark,
  input  logic [AW-1:0]    rd_addr,
  output logic [7:0]       rd_data,
  output logic [LW-1:0]    cnt,
  output logic [PAR_W-1:0] par,
  output logic             next_overflows
);
  logic [7:0]       sr_q, sr_n;
  logic [1:0]       pidx_q;
  logic [LW-1:0]    cnt_q;
  logic [PAR_W-1:0] par_q;
  logic [7:0]       mem [MAX_BYTES];
  logic             room, byte_full, wr_en;
  logic [7:0]       wr_byte;

  assign sr_n           = {pair, sr_q[7:2]};
  assign room           = (cnt_q != LW'(MAX_BYTES));
  assign byte_full      = pair_vld & (pidx_q == 2'd3);
  assign wr_en          = (byte_full & room) | (mark & (cnt_q == '0));
  assign wr_byte        = mark ? EMPTY_MARK : sr_n;
  assign next_overflows = (pidx_q == 2'd3) & ~room;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      pidx_q <= '0;
      cnt_q  <= '0;
      par_q  <= '0;
    end else if (clr) begin
      sr_q   <= '0;
      pidx_q <= '0;
      cnt_q  <= '0;
      par_q  <= '0;
    end else begin
      if (pair_vld) begin
        sr_q   <= sr_n;
        pidx_q <= pidx_q + 2'd1;
      end
      if (wr_en) begin
        cnt_q <= cnt_q + LW'(1);
        par_q <= {par_q[PAR_W-2:0], odd_par_bit(wr_byte)};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[cnt_q[AW-1:0]] <= wr_byte;
  end

  assign rd_data = mem[rd_addr];
  assign cnt     = cnt_q;
  assign par     = par_q;
endmodule

// File: rtl/ppm_cmd_decoder.sv
module ppm_cmd_decoder
  import ppm_dec_pkg::*;
#(
  parameter int MAX_BYTES    = 32,
  parameter int QUIET_GROUPS = 8,
  parameter int PAR_W        = 32,
  parameter int GRP_W        = 4,
  localparam int AW          = $clog2(MAX_BYTES),
  localparam int LW          = $clog2(MAX_BYTES + 1),
  localparam int OW          = $clog2(GRP_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grp_vld,
  input  logic [GRP_W-1:0] grp_raw,
  input  logic [AW-1:0]    rd_addr,
  output logic [7:0]       rd_data,
  output logic             frame_done,
  output logic [LW-1:0]    frame_len,
  output logic [PAR_W-1:0] frame_parity,
  output logic [OW-1:0]    sync_ofs,
  output logic             frame_ovf
);
  dec_state_e    state_q, state_d;
  logic [1:0]    slot_q, slot_d;
  logic          half_q, half_d;
  logic [2:0]    pos_q, pos_d, pos_t;
  logic [OW-1:0] ofs_q, ofs_d, hit_ofs;
  logic          ovf_q, ovf_d, done_q;
  logic [GRP_W-1:0] drops;
  logic          d, hit, bad, end_evt, clr, pair_vld, mark, next_ovf;

  assign drops = ~grp_raw;
  assign d     = drops[ofs_q];

  ppm_sync_finder #(.QUIET(QUIET_GROUPS), .GW(GRP_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .en(state_q == DS_IDLE), .vld(grp_vld),
    .drops(drops), .hit(hit), .ofs(hit_ofs)
  );

  ppm_byte_packer #(.MAX_BYTES(MAX_BYTES), .PAR_W(PAR_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .clr(clr), .pair_vld(pair_vld), .pair(pos_t[1:0]),
    .mark(mark), .rd_addr(rd_addr), .rd_data(rd_data), .cnt(frame_len),
    .par(frame_parity), .next_overflows(next_ovf)
  );

  always_comb begin
    state_d  = state_q;
    slot_d   = slot_q;
    half_d   = half_q;
    pos_d    = pos_q;
    ofs_d    = ofs_q;
    ovf_d    = ovf_q;
    pos_t    = pos_q;
    bad      = 1'b0;
    end_evt  = 1'b0;
    clr      = 1'b0;
    pair_vld = 1'b0;
    mark     = 1'b0;
    if (state_q == DS_IDLE) begin
      if (hit) begin
        state_d = DS_SOF;
        slot_d  = '0;
        half_d  = 1'b0;
        pos_d   = '0;
        ofs_d   = hit_ofs;
        ovf_d   = 1'b0;
        clr     = 1'b1;
      end
    end else if (grp_vld) begin
      if (!half_q) begin
        half_d = 1'b1;
        if (d && state_q == DS_RECV) begin
          state_d = DS_IDLE;
          if (slot_q == 2'd0) begin
            end_evt = 1'b1;
            mark    = 1'b1;
          end
        end
      end else begin
        half_d = 1'b0;
        if (d) begin
          if (pos_q != 3'd0) bad = 1'b1;
          else               pos_t = {1'b0, slot_q} + 3'd1;
        end
        if (bad) begin
          state_d = DS_IDLE;
        end else if (slot_q == 2'd3) begin
          slot_d = '0;
          pos_d  = '0;
          if (pos_t == 3'd0) begin
            state_d = DS_IDLE;
          end else if (state_q == DS_SOF) begin
            state_d = (pos_t >= 3'd3) ? DS_RECV : DS_IDLE;
          end else begin
            pair_vld = 1'b1;
            if (next_ovf) begin
              end_evt = 1'b1;
              ovf_d   = 1'b1;
              state_d = DS_IDLE;
            end
          end
        end else begin
          slot_d = slot_q + 2'd1;
          pos_d  = pos_t;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DS_IDLE;
      slot_q  <= '0;
      half_q  <= 1'b0;
      pos_q   <= '0;
      ofs_q   <= '0;
      ovf_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
      half_q  <= half_d;
      pos_q   <= pos_d;
      ofs_q   <= ofs_d;
      ovf_q   <= ovf_d;
      done_q  <= end_evt;
    end
  end

  assign frame_done = done_q;
  assign sync_ofs   = ofs_q;
  assign frame_ovf  = ovf_q;
endmodule

// File: rtl/ppm_cmd_decoder_chk.sv
module ppm_cmd_decoder_chk #(
  parameter int MAX_BYTES = 32,
  parameter int GRP_W     = 4,
  localparam int LW       = $clog2(MAX_BYTES + 1),
  localparam int OW       = $clog2(GRP_W)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          grp_vld,
  input logic          frame_done,
  input logic [LW-1:0] frame_len,
  input logic [OW-1:0] sync_ofs,
  input logic          frame_ovf
);
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R11
  len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_len <= LW'(MAX_BYTES));

  // R11
  ovf_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && frame_ovf) |-> (frame_len == LW'(MAX_BYTES)));

  // R8
  done_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (frame_len != '0));

  // R13
  done_after_grp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(grp_vld));

  // R12
  ofs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $stable(sync_ofs));
endmodule

bind ppm_cmd_decoder ppm_cmd_decoder_chk #(.MAX_BYTES(MAX_BYTES), .GRP_W(GRP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .grp_vld(grp_vld), .frame_done(frame_done),
  .frame_len(frame_len), .sync_ofs(sync_ofs), .frame_ovf(frame_ovf)
);

// File: tb/tb_ppm_cmd_decoder.sv
module tb_ppm_cmd_decoder;
  localparam int CLK_NS = 10;
  localparam int MAXB   = 32;
  localparam int QUIET  = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        grp_vld = 1'b0;
  logic [3:0]  grp_raw = 4'hF;
  logic [4:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        frame_done;
  logic [5:0]  frame_len;
  logic [31:0] frame_parity;
  logic [1:0]  sync_ofs;
  logic        frame_ovf;

  int n_tests = 0, n_fail = 0, n_done = 0;
  bit finished = 0, gap_mode = 0;

  ppm_cmd_decoder dut (
    .clk(clk), .rst_n(rst_n), .grp_vld(grp_vld), .grp_raw(grp_raw), .rd_addr(rd_addr),
    .rd_data(rd_data), .frame_done(frame_done), .frame_len(frame_len),
    .frame_parity(frame_parity), .sync_ofs(sync_ofs), .frame_ovf(frame_ovf)
  );

  always #(CLK_NS/2) clk = ~clk;

  // behavioural reference, updated at each rising edge
  int m_mode, m_quiet, m_ph, m_pos, m_ofs, m_cnt, m_bits, m_slot;
  logic [31:0] m_par;
  logic [7:0]  m_sr;
  logic [3:0]  m_dm;
  bit m_ovf, m_done, m_d;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_quiet = 0; m_ph = 0; m_pos = 0; m_ofs = 0; m_cnt = 0;
      m_bits = 0; m_par = 0; m_sr = 0; m_ovf = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (grp_vld) begin
        m_dm = ~grp_raw;
        if (m_mode == 0) begin
          if (m_dm == 0) begin
            if (m_quiet < QUIET) m_quiet++;
          end else begin
            if (m_quiet == QUIET) begin
              m_mode = 1;
              m_ofs = m_dm[3] ? 3 : m_dm[2] ? 2 : m_dm[1] ? 1 : 0;
              m_ph = 0; m_pos = 0; m_cnt = 0; m_par = 0; m_sr = 0; m_bits = 0; m_ovf = 0;
            end
            m_quiet = 0;
          end
        end else begin
          m_quiet = 0;
          m_d = m_dm[m_ofs];
          m_slot = m_ph / 2;
          if (m_ph % 2 == 0) begin
            if (m_d && m_mode == 2) begin
              m_mode = 0;
              if (m_slot == 0) begin
                if (m_cnt == 0) begin m_cnt = 1; m_par = {m_par[30:0], 1'b1}; end
                m_done = 1;
              end
            end else m_ph++;
          end else begin
            if (m_d) begin
              if (m_pos != 0) m_mode = 0;
              else m_pos = m_slot + 1;
            end
            if (m_mode != 0) begin
              if (m_slot == 3) begin
                if (m_pos == 0) m_mode = 0;
                else if (m_mode == 1) m_mode = (m_pos >= 3) ? 2 : 0;
                else begin
                  m_sr = {2'(m_pos % 4), m_sr[7:2]};
                  m_bits += 2;
                  if (m_bits == 8) begin
                    m_bits = 0;
                    if (m_cnt == MAXB) begin m_ovf = 1; m_done = 1; m_mode = 0; end
                    else begin m_par = {m_par[30:0], ~^m_sr}; m_cnt++; end
                  end
                end
                m_ph = 0; m_pos = 0;
              end else m_ph++;
            end
          end
        end
      end
    end
  end

  // cycle-by-cycle comparison against the reference (R12 timing)
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (frame_done) n_done++;
      n_tests++;
      if (frame_done !== m_done || int'(frame_len) != m_cnt || frame_parity !== m_par ||
          int'(sync_ofs) != m_ofs || frame_ovf !== m_ovf) begin
        n_fail++;
        $display("FAIL R12 cycle compare: actual done=%0b len=%0d par=%h ofs=%0d ovf=%0b expected done=%0b len=%0d par=%h ofs=%0d ovf=%0b",
                 frame_done, frame_len, frame_parity, sync_ofs, frame_ovf,
                 m_done, m_cnt, m_par, m_ofs, m_ovf);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive one group by its drop mask; the bench does the inversion (R2)
  task automatic grp(input bit v, input logic [3:0] drops);
    if (gap_mode && v) begin
      @(negedge clk); grp_vld = 1'b0; grp_raw = 4'h0;
    end
    @(negedge clk); grp_vld = v; grp_raw = ~drops;
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) grp(1, 4'h0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) grp(0, 4'h0);
  endtask

  // slot 1..4 places the drop in that slot's second half; 0 sends no drop
  task automatic sym(input int slot, input int ofs, input logic [3:0] noise);
    for (int g = 0; g < 8; g++)
      grp(1, noise | ((g == 2*slot - 1) ? 4'(1 << ofs) : 4'h0));
  endtask

  task automatic send_byte(input logic [7:0] b, input int ofs, input logic [3:0] noise);
    for (int k = 0; k < 4; k++) begin
      int pr;
      pr = (b >> (2*k)) & 3;
      sym(pr == 0 ? 4 : pr, ofs, noise);
    end
  endtask

  task automatic start_frame(input logic [3:0] sync_drops, input int ofs, input int sof_slot);
    quiet(10);
    grp(1, sync_drops);
    sym(sof_slot, ofs, 4'h0);
  endtask

  task automatic eof(input int ofs);
    grp(1, 4'(1 << ofs));
    idle(3);
  endtask

  task automatic check_frame(input string tag, input logic [7:0] exp[$], input bit exp_ovf,
                             input int base_done);
    logic [31:0] p;
    p = 0;
    check({tag, " done count"}, n_done - base_done, 1);
    check({tag, " frame_len"}, int'(frame_len), exp.size());
    check({tag, " frame_ovf"}, int'(frame_ovf), int'(exp_ovf));
    foreach (exp[i]) p = {p[30:0], ~^exp[i]};
    check({tag, " R10 parity"}, int'(frame_parity), int'(p));
    foreach (exp[i]) begin
      rd_addr = 5'(i);
      #1;
      check({tag, " byte"}, int'(rd_data), int'(exp[i]));
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL R12 watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] q[$];
    int base;
    idle(3);
    // R1 reset values
    check("R1 frame_done", int'(frame_done), 0);
    check("R1 frame_len", int'(frame_len), 0);
    check("R1 frame_parity", int'(frame_parity), 0);
    check("R1 sync_ofs", int'(sync_ofs), 0);
    check("R1 frame_ovf", int'(frame_ovf), 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    // R6 two bytes, lane 0, start symbol slot 4
    base = n_done;
    start_frame(4'b0001, 0, 4);
    send_byte(8'hB4, 0, 4'h0);
    send_byte(8'h00, 0, 4'h0);
    eof(0);
    q = '{8'hB4, 8'h00};
    check_frame("R6 two-byte frame", q, 0, base);
    check("R4 lane 0", int'(sync_ofs), 0);
    quiet(5);
    check("R12 length held", int'(frame_len), 2);
    check("R12 single pulse", n_done - base, 1);

    // R4 / R2 lock lane 2 from mask 0111, noise on lane 0; start slot 3 (R5)
    base = n_done;
    start_frame(4'b0111, 2, 3);
    send_byte(8'h5A, 2, 4'b0001);
    send_byte(8'hC3, 2, 4'b0001);
    eof(2);
    q = '{8'h5A, 8'hC3};
    check_frame("R4 lane 2 with noise", q, 0, base);
    check("R4 sync_ofs", int'(sync_ofs), 2);

    // R8 empty frame gives 0xF0
    base = n_done;
    start_frame(4'b1000, 3, 4);
    eof(3);
    q = '{8'hF0};
    check_frame("R8 empty frame", q, 0, base);
    check("R4 lane 3", int'(sync_ofs), 3);

    // R9 first-half drop ignored in start symbol; R8 partial byte dropped
    base = n_done;
    quiet(10);
    grp(1, 4'b0010);
    for (int g = 0; g < 8; g++) grp(1, (g == 4 || g == 7) ? 4'b0010 : 4'h0);
    send_byte(8'h3C, 1, 4'h0);
    sym(2, 1, 4'h0);
    sym(1, 1, 4'h0);
    eof(1);
    q = '{8'h3C};
    check_frame("R9 R8 start-half ignored, partial dropped", q, 0, base);

    // R5 bad start symbol slot 2
    base = n_done;
    start_frame(4'b0001, 0, 2);
    send_byte(8'h11, 0, 4'h0);
    eof(0);
    check("R5 bad start symbol discarded", n_done - base, 0);
    idle(2);

    // R3 only seven quiet groups before lock attempt
    base = n_done;
    quiet(7);
    grp(1, 4'b0001);
    sym(4, 0, 4'h0);
    send_byte(8'hFF, 0, 4'h0);
    eof(0);
    check("R3 short quiet no lock", n_done - base, 0);

    // R7 double drop in a symbol
    base = n_done;
    start_frame(4'b0001, 0, 4);
    send_byte(8'h21, 0, 4'h0);
    for (int g = 0; g < 8; g++) grp(1, (g == 1 || g == 5) ? 4'b0001 : 4'h0);
    eof(0);
    check("R7 double drop discarded", n_done - base, 0);

    // R7 symbol with no drop
    base = n_done;
    start_frame(4'b0001, 0, 4);
    sym(0, 0, 4'h0);
    eof(0);
    check("R7 empty symbol discarded", n_done - base, 0);

    // R9 first-half drop in slot 2 while receiving
    base = n_done;
    start_frame(4'b0001, 0, 3);
    for (int g = 0; g < 8; g++) grp(1, (g == 2) ? 4'b0001 : 4'h0);
    eof(0);
    check("R9 first-half slot 2 discarded", n_done - base, 0);

    // R13 gaps with garbage on grp_raw while invalid
    gap_mode = 1;
    base = n_done;
    start_frame(4'b0100, 2, 4);
    send_byte(8'h96, 2, 4'h0);
    eof(2);
    gap_mode = 0;
    q = '{8'h96};
    check_frame("R13 gaps ignored", q, 0, base);

    // R11 overflow at MAXB
    base = n_done;
    q.delete();
    start_frame(4'b0001, 0, 4);
    for (int i = 0; i <= MAXB; i++) begin
      logic [7:0] b;
      b = 8'((i * 7 + 1) & 8'hFF);
      send_byte(b, 0, 4'h0);
      if (i < MAXB) q.push_back(b);
    end
    eof(0);
    check_frame("R11 overflow", q, 1, base);

    idle(3);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule